// File: doc/BRIEF.md
# Processor Interrupt Intake and Priority Resolver

This block gathers every interrupt source of a small 8-bit processor and, at each instruction boundary, hands the sequencer one winning request with its fixed vector address. There are five sources. The first is an unmaskable trap that needs a rising edge followed by a held level. The second is a high restart input whose rising edge is latched. The third and fourth are a middle and a low restart input, both purely level sensitive. The last is a general request with no vector of its own. The three restart inputs can each be masked. All sources except the trap are gated by a global interrupt-enable flag.

Software controls the block through a set-mask write port and a combinational read-mask port, and through enable and disable strobes. The sequencer marks the last clock of each instruction with `instr_last` and accepts an offered request with `ack`. A trap acceptance saves the enable flag so that the first read afterwards still reports the enable state the trap interrupted.

Control is a two-state machine. `ST_WAIT` moves to `ST_OFFER` when `instr_last` is high and at least one source is eligible; this transition is called *grant*. `ST_OFFER` holds the captured source and vector and moves back to `ST_WAIT` when `ack` is high; this transition is called *accept*. There are no other transitions.

Top module: `irq_front`

## Requirements
- R1: After reset no request is offered, the enable flag is 0, all three masks are set, and with all inputs low `mask_rdata` reads 0x07.
- R2: A trap is offered when its rising edge has been seen and `trap_in` is still high at a boundary. This happens even with the enable flag cleared and all masks set. It uses code 4 and vector 0x0024.
- R3: After a trap is accepted, a new trap needs `trap_in` to go low and rise again. A trap pulse that falls before the boundary is not offered.
- R4: Accepting a trap clears the enable flag. The first read access afterwards returns the pre-trap enable state in bit 3, and later reads return the current flag.
- R5: A write with bit 3 set loads the masks from bits 2:0 (bit 0 low, bit 1 middle, bit 2 high). A write with bit 3 clear leaves the masks as they are. A masked restart is never offered.
- R6: A rising edge on the high restart input sets a pending latch, even while it is masked. The latch is shown in read bit 6 and is cleared by its own acceptance or by a write with bit 4 set. The request uses code 3 and vector 0x003C.
- R7: The middle and low restart inputs count only while high at the boundary and are not latched. They are shown in read bits 5 and 4. Middle uses code 2 and vector 0x0034; low uses code 1 and vector 0x002C.
- R8: The general request is evaluated only in a cycle with `instr_last` high. It uses code 0 and vector 0x0000.
- R9: The enable strobe sets the enable flag and the disable strobe clears it. Accepting any maskable request clears it. No maskable source is offered while the flag is 0.
- R10: Among eligible sources the winner is, in order, trap, high, middle, low, general, whichever routine is running.
- R11: An offered request keeps its code and vector stable until `ack`, and is withdrawn in the cycle after `ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_in | input | 1 | Unmaskable trap input |
| rst_hi_in | input | 1 | High restart input, edge latched |
| rst_mid_in | input | 1 | Middle restart input, level |
| rst_lo_in | input | 1 | Low restart input, level |
| gen_req_in | input | 1 | General request input |
| instr_last | input | 1 | Last clock of the current instruction |
| ei_strobe | input | 1 | Set the enable flag |
| di_strobe | input | 1 | Clear the enable flag |
| mask_wr | input | 1 | Set-mask write strobe |
| mask_wdata | input | 8 | Set-mask write data |
| mask_rd | input | 1 | Read-mask access strobe |
| mask_rdata | output | 8 | Read-mask data: masks, enable, pending |
| ack | input | 1 | Sequencer accepts the offered request |
| req_valid | output | 1 | A request is offered |
| req_src | output | 3 | Source code of the offered request |
| req_vec | output | 16 | Vector address of the offered request |

## Verification
The hardest situation to reach is the saved enable flag. The first read after a trap must differ from the current flag, and that can only be seen when a trap is taken while the flag is set. The stimulus enables interrupts, raises and holds the trap, and accepts it. It then performs two read accesses in a row, expecting 1 and then 0. With the trap still held high, it confirms that no second trap appears until the input has fallen and risen again.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int VEC_W  = 16;
    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        SRC_GEN  = 3'd0,
        SRC_LO   = 3'd1,
        SRC_MID  = 3'd2,
        SRC_HI   = 3'd3,
        SRC_TRAP = 3'd4
    } src_e;

    typedef enum logic {
        ST_WAIT,
        ST_OFFER
    } state_e;

    function automatic logic [VEC_W-1:0] vec_of(input src_e s);
        logic [VEC_W-1:0] v;
        unique case (s)
            SRC_TRAP: v = VEC_W'(16'h0024);
            SRC_HI:   v = VEC_W'(16'h003C);
            SRC_MID:  v = VEC_W'(16'h0034);
            SRC_LO:   v = VEC_W'(16'h002C);
            default:  v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    input  logic clr,
    output logic pend
);
    logic prev_q;
    logic pend_q;
    logic rise;

    assign rise = sig & ~prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            prev_q <= sig;
            if (rise)
                pend_q <= 1'b1;
            else if (clr)
                pend_q <= 1'b0;
        end
    end

    assign pend = pend_q;
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import irq_pkg::*;
#(
    parameter int NUM_RST = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mask_wr,
    input  logic [DATA_W-1:0]  mask_wdata,
    input  logic               mask_rd,
    input  logic               ei_strobe,
    input  logic               di_strobe,
    input  logic               acc_mask,
    input  logic               acc_trap,
    output logic [NUM_RST-1:0] mask,
    output logic               ie,
    output logic               rd_ie,
    output logic               hi_clr_sw
);
    localparam int MSE_BIT = NUM_RST;
    localparam int CLR_BIT = NUM_RST + 1;

    logic [NUM_RST-1:0] mask_q;
    logic               ie_q;
    logic               shadow_ie_q;
    logic               shadow_vld_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q       <= '1;
            ie_q         <= 1'b0;
            shadow_ie_q  <= 1'b0;
            shadow_vld_q <= 1'b0;
        end else begin
            if (mask_wr && mask_wdata[MSE_BIT])
                mask_q <= mask_wdata[NUM_RST-1:0];

            if (acc_mask || acc_trap || di_strobe)
                ie_q <= 1'b0;
            else if (ei_strobe)
                ie_q <= 1'b1;

            if (acc_trap) begin
                shadow_ie_q  <= ie_q;
                shadow_vld_q <= 1'b1;
            end else if (mask_rd) begin
                shadow_vld_q <= 1'b0;
            end
        end
    end

    assign mask      = mask_q;
    assign ie        = ie_q;
    assign rd_ie     = shadow_vld_q ? shadow_ie_q : ie_q;
    assign hi_clr_sw = mask_wr & mask_wdata[CLR_BIT];
endmodule

// File: rtl/irq_arb.sv
module irq_arb
    import irq_pkg::*;
(
    input  logic trap_ok,
    input  logic hi_ok,
    input  logic mid_ok,
    input  logic lo_ok,
    input  logic gen_ok,
    output logic any,
    output src_e win
);
    always_comb begin
        any = 1'b1;
        win = SRC_GEN;
        if (trap_ok)
            win = SRC_TRAP;
        else if (hi_ok)
            win = SRC_HI;
        else if (mid_ok)
            win = SRC_MID;
        else if (lo_ok)
            win = SRC_LO;
        else if (gen_ok)
            win = SRC_GEN;
        else
            any = 1'b0;
    end
endmodule

// File: rtl/irq_front.sv
module irq_front
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trap_in,
    input  logic              rst_hi_in,
    input  logic              rst_mid_in,
    input  logic              rst_lo_in,
    input  logic              gen_req_in,
    input  logic              instr_last,
    input  logic              ei_strobe,
    input  logic              di_strobe,
    input  logic              mask_wr,
    input  logic [DATA_W-1:0] mask_wdata,
    input  logic              mask_rd,
    output logic [DATA_W-1:0] mask_rdata,
    input  logic              ack,
    output logic              req_valid,
    output logic [2:0]        req_src,
    output logic [VEC_W-1:0]  req_vec
);
    localparam int NUM_RST = 3;
    localparam int PAD_W   = DATA_W - 2 * NUM_RST - 1;

    state_e state_q, state_d;
    src_e   src_q,   src_d;

    logic             trap_pend, hi_pend;
    logic             trap_clr,  hi_clr, hi_clr_sw;
    logic [NUM_RST-1:0] mask;
    logic             ie_q, rd_ie;
    logic             acc, acc_trap, acc_mask;
    logic             trap_ok, hi_ok, mid_ok, lo_ok, gen_ok;
    logic             any;
    src_e             win;

    irq_edge_latch u_trap (
        .clk(clk), .rst_n(rst_n), .sig(trap_in), .clr(trap_clr), .pend(trap_pend)
    );

    irq_edge_latch u_hi (
        .clk(clk), .rst_n(rst_n), .sig(rst_hi_in), .clr(hi_clr), .pend(hi_pend)
    );

    irq_ctrl #(.NUM_RST(NUM_RST)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .mask_wr(mask_wr), .mask_wdata(mask_wdata), .mask_rd(mask_rd),
        .ei_strobe(ei_strobe), .di_strobe(di_strobe),
        .acc_mask(acc_mask), .acc_trap(acc_trap),
        .mask(mask), .ie(ie_q), .rd_ie(rd_ie), .hi_clr_sw(hi_clr_sw)
    );

    assign trap_ok = trap_pend & trap_in;
    assign hi_ok   = ie_q & hi_pend    & ~mask[2];
    assign mid_ok  = ie_q & rst_mid_in & ~mask[1];
    assign lo_ok   = ie_q & rst_lo_in  & ~mask[0];
    assign gen_ok  = ie_q & gen_req_in;

    irq_arb u_arb (
        .trap_ok(trap_ok), .hi_ok(hi_ok), .mid_ok(mid_ok), .lo_ok(lo_ok),
        .gen_ok(gen_ok), .any(any), .win(win)
    );

    always_comb begin
        state_d = state_q;
        src_d   = src_q;
        unique case (state_q)
            ST_WAIT: begin
                if (instr_last && any) begin
                    state_d = ST_OFFER;
                    src_d   = win;
                end
            end
            ST_OFFER: begin
                if (ack)
                    state_d = ST_WAIT;
            end
            default: state_d = ST_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_WAIT;
            src_q   <= SRC_GEN;
        end else begin
            state_q <= state_d;
            src_q   <= src_d;
        end
    end

    always_comb begin
        req_valid = (state_q == ST_OFFER);
        req_src   = src_q;
        req_vec   = req_valid ? vec_of(src_q) : '0;
    end

    assign acc      = req_valid & ack;
    assign acc_trap = acc & (src_q == SRC_TRAP);
    assign acc_mask = acc & (src_q != SRC_TRAP);
    assign trap_clr = acc_trap;
    assign hi_clr   = (acc & (src_q == SRC_HI)) | hi_clr_sw;

    assign mask_rdata = {{PAD_W{1'b0}}, hi_pend, rst_mid_in, rst_lo_in, rd_ie, mask};
endmodule

// File: rtl/irq_front_chk.sv
module irq_front_chk
    import irq_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        trap_in,
    input logic        rst_hi_in,
    input logic        instr_last,
    input logic        ack,
    input logic        req_valid,
    input logic [2:0]  req_src,
    input logic [15:0] req_vec,
    input logic        ie_q,
    input logic        hi_pend
);
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !ack) |=> (req_valid && $stable(req_src) && $stable(req_vec)));

    p_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ack) |=> !req_valid);

    p_boundary_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_valid) |-> $past(instr_last));

    p_ie_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(req_valid) && req_src != 3'(SRC_TRAP)) |-> $past(ie_q));

    p_trap_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(req_valid) && req_src == 3'(SRC_TRAP)) |-> $past(trap_in));

    p_hi_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_hi_in) |=> hi_pend);

    p_hi_vec_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_src == 3'(SRC_HI)) |-> (req_vec == 16'h003C));
endmodule

bind irq_front irq_front_chk u_chk (
    .clk(clk), .rst_n(rst_n), .trap_in(trap_in), .rst_hi_in(rst_hi_in),
    .instr_last(instr_last), .ack(ack), .req_valid(req_valid),
    .req_src(req_src), .req_vec(req_vec), .ie_q(ie_q), .hi_pend(hi_pend)
);

// File: tb/sim_irq_front.sv
module sim_irq_front;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trap_in = 0, rst_hi_in = 0, rst_mid_in = 0, rst_lo_in = 0, gen_req_in = 0;
    logic        instr_last = 0, ei_strobe = 0, di_strobe = 0, mask_wr = 0, mask_rd = 0, ack = 0;
    logic [7:0]  mask_wdata = 8'h00;
    logic [7:0]  mask_rdata;
    logic        req_valid;
    logic [2:0]  req_src;
    logic [15:0] req_vec;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    irq_front u0 (
        .clk(clk), .rst_n(rst_n), .trap_in(trap_in), .rst_hi_in(rst_hi_in),
        .rst_mid_in(rst_mid_in), .rst_lo_in(rst_lo_in), .gen_req_in(gen_req_in),
        .instr_last(instr_last), .ei_strobe(ei_strobe), .di_strobe(di_strobe),
        .mask_wr(mask_wr), .mask_wdata(mask_wdata), .mask_rd(mask_rd),
        .mask_rdata(mask_rdata), .ack(ack), .req_valid(req_valid),
        .req_src(req_src), .req_vec(req_vec)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic boundary();
        instr_last = 1; cyc(); instr_last = 0;
    endtask

    task automatic do_ack();
        ack = 1; cyc(); ack = 0;
    endtask

    task automatic enable();
        ei_strobe = 1; cyc(); ei_strobe = 0;
    endtask

    task automatic wr_mask(input logic [7:0] d);
        mask_wr = 1; mask_wdata = d; cyc(); mask_wr = 0; mask_wdata = 8'h00;
    endtask

    task automatic expect_req(input string req, input int src, input int vec);
        chk(req, req_valid, 1);
        chk(req, req_src, src);
        chk(req, req_vec, vec);
    endtask

    task automatic t_reset();
        chk("R1", req_valid, 0);
        chk("R1", mask_rdata, 8'h07);
        gen_req_in = 1; boundary();
        chk("R1", req_valid, 0);
        gen_req_in = 0;
    endtask

    task automatic t_trap_unmaskable();
        trap_in = 1; cyc();
        boundary();
        expect_req("R2", 4, 16'h0024);
        cyc();
        chk("R11", req_valid, 1);
        chk("R11", req_src, 4);
        do_ack();
        chk("R11", req_valid, 0);
        boundary();
        chk("R3", req_valid, 0);
        trap_in = 0; cyc();
        trap_in = 1; cyc(); trap_in = 0; cyc();
        boundary();
        chk("R3", req_valid, 0);
    endtask

    task automatic t_trap_shadow();
        enable();
        trap_in = 1; cyc();
        boundary();
        expect_req("R4", 4, 16'h0024);
        do_ack();
        mask_rd = 1;
        chk("R4", mask_rdata[3], 1);
        cyc(); mask_rd = 0;
        chk("R4", mask_rdata[3], 0);
        trap_in = 0; cyc();
    endtask

    task automatic t_mask_write();
        wr_mask(8'h08);
        chk("R5", mask_rdata[2:0], 0);
        wr_mask(8'h07);
        chk("R5", mask_rdata[2:0], 0);
        wr_mask(8'h0D);
        chk("R5", mask_rdata[2:0], 5);
        enable();
        rst_lo_in = 1; cyc();
        boundary();
        chk("R5", req_valid, 0);
        rst_lo_in = 0;
        rst_mid_in = 1; boundary();
        expect_req("R7", 2, 16'h0034);
        do_ack();
        rst_mid_in = 0;
        chk("R9", mask_rdata[3], 0);
        wr_mask(8'h08);
    endtask

    task automatic t_hi_latch();
        enable();
        rst_hi_in = 1; cyc(); rst_hi_in = 0; cyc();
        chk("R6", mask_rdata[6], 1);
        boundary();
        expect_req("R6", 3, 16'h003C);
        do_ack();
        chk("R6", mask_rdata[6], 0);
        rst_hi_in = 1; cyc(); rst_hi_in = 0; cyc();
        wr_mask(8'h10);
        chk("R6", mask_rdata[6], 0);
        enable();
        boundary();
        chk("R6", req_valid, 0);
        wr_mask(8'h0C);
        rst_hi_in = 1; cyc(); rst_hi_in = 0; cyc();
        chk("R6", mask_rdata[6], 1);
        boundary();
        chk("R5", req_valid, 0);
        wr_mask(8'h18);
    endtask

    task automatic t_levels_and_gen();
        enable();
        rst_lo_in = 1; cyc();
        chk("R7", mask_rdata[4], 1);
        rst_lo_in = 0; cyc();
        boundary();
        chk("R7", req_valid, 0);
        rst_lo_in = 1; boundary();
        expect_req("R7", 1, 16'h002C);
        do_ack(); rst_lo_in = 0;
        enable();
        gen_req_in = 1;
        for (int i = 0; i < 4; i++) begin
            cyc();
            chk("R8", req_valid, 0);
        end
        boundary();
        expect_req("R8", 0, 0);
        do_ack(); gen_req_in = 0;
    endtask

    task automatic t_enable();
        enable(); di_strobe = 1; cyc(); di_strobe = 0;
        chk("R9", mask_rdata[3], 0);
        rst_mid_in = 1; boundary();
        chk("R9", req_valid, 0);
        enable();
        chk("R9", mask_rdata[3], 1);
        boundary();
        expect_req("R9", 2, 16'h0034);
        do_ack(); rst_mid_in = 0;
        chk("R9", mask_rdata[3], 0);
    endtask

    task automatic t_priority();
        rst_hi_in = 1; cyc(); rst_hi_in = 0;
        rst_mid_in = 1; rst_lo_in = 1; gen_req_in = 1;
        trap_in = 1; cyc();
        boundary();
        expect_req("R10", 4, 16'h0024);
        do_ack(); trap_in = 0;
        enable(); boundary();
        expect_req("R10", 3, 16'h003C);
        do_ack();
        enable(); boundary();
        expect_req("R10", 2, 16'h0034);
        do_ack(); rst_mid_in = 0;
        enable(); boundary();
        expect_req("R10", 1, 16'h002C);
        do_ack(); rst_lo_in = 0;
        enable(); boundary();
        expect_req("R10", 0, 0);
        do_ack(); gen_req_in = 0;
    endtask

    initial begin
        repeat (3) cyc();
        rst_n = 1; cyc();
        t_reset();
        t_trap_unmaskable();
        t_trap_shadow();
        t_mask_write();
        t_hi_latch();
        t_levels_and_gen();
        t_enable();
        t_priority();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule